// File: doc/BRIEF.md
# Three-Tier Nested Interrupt Arbiter

This block sits between a set of interrupt request lines and a small 8-bit CPU. It decides which interrupt the CPU takes next. There are ten vector slots. Each slot is given one of three priority tiers by a configuration bit. The block also keeps the tier of every interrupt now being serviced, so that handlers can nest: a new request is taken only when its tier is strictly above the tier currently in service.

When a request is eligible, the block raises `irq_o`. The CPU answers by holding `accept_i` high for a clock edge. On that edge the block latches the winning slot's vector address and pulses `ack_o` for one cycle. It also pushes the winner's tier onto a small in-service stack. A return-from-interrupt strobe pops that stack, which restores the tier of the handler that was interrupted.

The block never clears request flags. The requester drops its own flag once the handler has been entered. Slot 6 has no source, and anything driven on its request line is discarded.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, `ack_o` is 0, `vec_o` is 0, `cur_tier_o` is 0 (nothing in service) and `irq_o` is 0 while no request is pending.
- R2: Tier codes on `cur_tier_o` are 0 = none, 1 = low, 2 = high, 3 = top. For slots 0 and 1, `tier_sel_i` bit = 1 selects top and 0 selects low. For slots 2 to 9, bit = 1 selects high and 0 selects low.
- R3: A pending request is eligible only if its tier is strictly greater than `cur_tier_o`. Requests at an equal or lower tier are held off: they raise no `irq_o` and get no `ack_o`.
- R4: When eligible requests sit at different tiers, the request with the greatest tier wins.
- R5: Among eligible requests of the same winning tier, the one with the lowest slot index wins.
- R6: The vector for slot i is 0x03 + 8·i (0x03, 0x0B, …, 0x4B). `vec_o` carries this value only in a cycle where `ack_o` is 1, and is 0 otherwise.
- R7: `ack_o` is 1 for the single cycle after a clock edge at which `accept_i` = 1, `irq_o` = 1 and `reti_i` = 0. With `accept_i` = 0, no interrupt is taken and `cur_tier_o` does not change.
- R8: Each taken interrupt pushes its tier, and `cur_tier_o` shows that tier from the cycle after the edge. Each `reti_i` pulse pops one entry, which restores the tier that was in service before. A `reti_i` pulse with nothing in service has no effect.
- R9: When `reti_i` and `accept_i` are both 1 at the same edge, only the pop happens and no interrupt is taken in that cycle.
- R10: A request on slot 6 is ignored. It never raises `irq_o` and never produces vector 0x33.
- R11: `irq_o` is 1 exactly when at least one eligible request is pending, as a combinational function of `req_i`, `tier_sel_i` and the tier in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 10 | Pending request flag per slot |
| tier_sel_i | input | 10 | Per-slot tier select bit (see R2) |
| accept_i | input | 1 | CPU takes the presented interrupt at this edge |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | An eligible request is pending |
| ack_o | output | 1 | One-cycle acknowledge of a taken interrupt |
| vec_o | output | 8 | Vector address of the taken interrupt, valid with ack_o |
| cur_tier_o | output | 2 | Tier now in service (0 = none) |

## Verification
The hardest state to reach is a three-deep nest: a low handler interrupted by a high one, which is in turn interrupted by a top one. The next step, a correct unwind through each pop, is harder still. Reaching it needs requests raised at rising tiers while earlier ones are still held. The stimulus also has to keep equal-tier requests asserted, so that the hold-off rule is seen to block them. A directed sequence builds this nest step by step and then pops past the empty point. A long pseudo-random phase keeps requests sticky until they are taken, so that deep nesting and simultaneous `reti_i`/`accept_i` edges keep recurring. A behavioural model with a queue checks every cycle.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [1:0] {
        TIER_NONE = 2'd0,
        TIER_LO   = 2'd1,
        TIER_MID  = 2'd2,
        TIER_TOP  = 2'd3
    } tier_e;

    localparam int TIER_W = 2;

endpackage

// File: rtl/irq_tier_pick.sv
// Combinational winner selection: greatest tier first, lowest index inside a tier.
module irq_tier_pick
    import irq_nest_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]             req_i,
    input  logic [NUM_SLOTS-1:0][TIER_W-1:0] tier_i,
    input  logic [TIER_W-1:0]                cur_i,
    output logic                             found_o,
    output logic [IDX_W-1:0]                 idx_o,
    output logic [TIER_W-1:0]                tier_o
);

    logic [NUM_SLOTS-1:0] elig;

    // eligibility: strictly above the tier in service
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_elig
        assign elig[g] = req_i[g] && (tier_i[g] > cur_i);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        tier_o  = TIER_NONE;
        // walk tiers upward so a higher tier overrides a lower one
        for (int t = 1; t < 4; t++) begin
            logic             hit;
            logic [IDX_W-1:0] pos;
            hit = 1'b0;
            pos = '0;
            // walk slots downward so the lowest index is kept
            for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
                if (elig[i] && (tier_i[i] == TIER_W'(t))) begin
                    hit = 1'b1;
                    pos = IDX_W'(i);
                end
            end
            if (hit) begin
                found_o = 1'b1;
                idx_o   = pos;
                tier_o  = TIER_W'(t);
            end
        end
    end

endmodule

// File: rtl/irq_tier_stack.sv
// Small LIFO of in-service tiers; empty reads as TIER_NONE.
module irq_tier_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [TIER_W-1:0] push_tier_i,
    input  logic              pop_i,
    output logic [TIER_W-1:0] top_o
);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [DEPTH-1:0][TIER_W-1:0] ent;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (pop_i) begin
            if (stk_q.cnt != '0) begin
                stk_d.cnt = stk_q.cnt - 1'b1;
            end
        end else if (push_i && (stk_q.cnt < CNT_W'(DEPTH))) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (stk_q.cnt == CNT_W'(k)) begin
                    stk_d.ent[k] = push_tier_i;
                end
            end
            stk_d.cnt = stk_q.cnt + 1'b1;
        end
    end

    always_comb begin
        top_o = TIER_NONE;
        for (int k = 0; k < DEPTH; k++) begin
            if (stk_q.cnt == CNT_W'(k + 1)) begin
                top_o = stk_q.ent[k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
    import irq_nest_pkg::*;
#(
    parameter int NUM_SLOTS  = 10,
    parameter int TOP_SLOTS  = 2,
    parameter int EMPTY_SLOT = 6,
    parameter int VEC_W      = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    parameter int NEST_DEPTH = 3,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic [NUM_SLOTS-1:0] tier_sel_i,
    input  logic                 accept_i,
    input  logic                 reti_i,
    output logic                 irq_o,
    output logic                 ack_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic [TIER_W-1:0]    cur_tier_o
);

    typedef struct packed {
        logic             ack;
        logic [VEC_W-1:0] vec;
    } out_t;

    out_t st_d, st_q;

    logic [NUM_SLOTS-1:0]             req_live;
    logic [NUM_SLOTS-1:0][TIER_W-1:0] slot_tier;
    logic                             found;
    logic [IDX_W-1:0]                 win_idx;
    logic [TIER_W-1:0]                win_tier;
    logic [TIER_W-1:0]                cur_tier;
    logic                             take;

    // per-slot tier mapping and removal of the unconnected slot
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g < TOP_SLOTS) begin : g_top
            assign slot_tier[g] = tier_sel_i[g] ? TIER_TOP : TIER_LO;
        end else begin : g_mid
            assign slot_tier[g] = tier_sel_i[g] ? TIER_MID : TIER_LO;
        end
        if (g == EMPTY_SLOT) begin : g_none
            assign req_live[g] = 1'b0;
        end else begin : g_live
            assign req_live[g] = req_i[g];
        end
    end

    irq_tier_pick #(
        .NUM_SLOTS(NUM_SLOTS)
    ) pick_i (
        .req_i  (req_live),
        .tier_i (slot_tier),
        .cur_i  (cur_tier),
        .found_o(found),
        .idx_o  (win_idx),
        .tier_o (win_tier)
    );

    assign take = accept_i && found && !reti_i;

    irq_tier_stack #(
        .DEPTH(NEST_DEPTH)
    ) stack_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (take),
        .push_tier_i(win_tier),
        .pop_i      (reti_i),
        .top_o      (cur_tier)
    );

    always_comb begin
        st_d.ack = take;
        st_d.vec = take ? VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_idx)) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = found;
    assign ack_o      = st_q.ack;
    assign vec_o      = st_q.vec;
    assign cur_tier_o = cur_tier;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int NUM_SLOTS = 10,
    parameter int VEC_W     = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_SLOTS-1:0] req_i,
    input logic                 accept_i,
    input logic                 reti_i,
    input logic                 irq_o,
    input logic                 ack_o,
    input logic [VEC_W-1:0]     vec_o,
    input logic [1:0]           cur_tier_o
);

    // R7
    ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> $past(accept_i && irq_o && !reti_i));

    // R3
    ack_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (cur_tier_o > $past(cur_tier_o)));

    // R9
    reti_noack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reti_i |=> !ack_o);

    // R6
    vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_o |-> (vec_o == '0));

    // R6
    vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (vec_o[2:0] == 3'b011));

    // R10
    empty_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ack_o && (vec_o == VEC_W'(8'h33))));

    // R7
    tier_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!accept_i && !reti_i) |=> $stable(cur_tier_o));

    // R11
    idle_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == '0) |-> !irq_o);

endmodule

bind irq_nest_arb irq_nest_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .VEC_W    (VEC_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .accept_i  (accept_i),
    .reti_i    (reti_i),
    .irq_o     (irq_o),
    .ack_o     (ack_o),
    .vec_o     (vec_o),
    .cur_tier_o(cur_tier_o)
);

// File: tb/irq_nest_arb_tb.sv
`timescale 1ns/1ps
module irq_nest_arb_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [9:0] req_i = '0;
    logic [9:0] tier_sel_i = '0;
    logic       accept_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       irq_o;
    logic       ack_o;
    logic [7:0] vec_o;
    logic [1:0] cur_tier_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    always #2 clk_i = ~clk_i;

    irq_nest_arb dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .tier_sel_i(tier_sel_i),
        .accept_i  (accept_i),
        .reti_i    (reti_i),
        .irq_o     (irq_o),
        .ack_o     (ack_o),
        .vec_o     (vec_o),
        .cur_tier_o(cur_tier_o)
    );

    // ---------------- behavioural reference ----------------
    int stk[$];
    bit e_ack = 0;
    int e_vec = 0;

    function automatic int tier_of(int i, bit sel);
        if (!sel) return 1;
        return (i < 2) ? 3 : 2;
    endfunction

    function automatic int cur_tier();
        return (stk.size() == 0) ? 0 : stk[$];
    endfunction

    function automatic int winner();
        int best = -1;
        int bt = 0;
        for (int i = 0; i < 10; i++) begin
            if (i != 6 && req_i[i] && tier_of(i, tier_sel_i[i]) > cur_tier()
                && tier_of(i, tier_sel_i[i]) > bt) begin
                best = i;
                bt = tier_of(i, tier_sel_i[i]);
            end
        end
        return best;
    endfunction

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stk.delete();
            e_ack = 0;
            e_vec = 0;
        end else if (reti_i) begin
            if (stk.size() != 0) void'(stk.pop_back());
            e_ack = 0;
            e_vec = 0;
        end else begin
            int w;
            w = winner();
            if (accept_i && w >= 0) begin
                stk.push_back(tier_of(w, tier_sel_i[w]));
                e_ack = 1;
                e_vec = 3 + 8 * w;
            end else begin
                e_ack = 0;
                e_vec = 0;
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: outputs sampled away from the edge, before inputs move
    task automatic tick();
        @(posedge clk_i);
        #1;
        cmp("ack_o", int'(ack_o), int'(e_ack));
        cmp("vec_o", int'(vec_o), e_vec);
        cmp("cur_tier_o", int'(cur_tier_o), cur_tier());
        cmp("irq_o", int'(irq_o), int'(winner() >= 0));
    endtask

    task automatic drive(logic [9:0] r, logic [9:0] s, bit acc, bit ret);
        req_i = r;
        tier_sel_i = s;
        accept_i = acc;
        reti_i = ret;
        tick();
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tag = "R1";
        #1;
        cmp("ack_o", int'(ack_o), 0);
        cmp("vec_o", int'(vec_o), 0);
        cmp("cur_tier_o", int'(cur_tier_o), 0);
        cmp("irq_o", int'(irq_o), 0);
        #5 rst_ni = 1'b1;
        tick();

        // R10 slot 6 ignored even with accept held
        tag = "R10";
        drive(10'b00_0100_0000, 10'h3FF, 1, 0);
        cmp("irq_o slot6", int'(irq_o), 0);
        drive(10'b00_0100_0000, 10'h000, 1, 0);
        cmp("cur_tier_o slot6", int'(cur_tier_o), 0);

        // R7 no accept: nothing taken
        tag = "R7";
        drive(10'b00_0000_1000, 10'h000, 0, 0);
        drive(10'b00_0000_1000, 10'h000, 0, 0);
        cmp("ack_o no accept", int'(ack_o), 0);

        // R4 top tier (slot 1) beats high (slot 2) and low (slot 0)
        tag = "R4";
        drive(10'b00_0000_0111, 10'b00_0000_0110, 1, 0);
        cmp("vec_o top wins", int'(vec_o), 8'h0B);
        drive(10'b00_0000_0101, 10'b00_0000_0110, 0, 1);

        // R5 same tier, lowest index (slot 4 over 8)
        tag = "R5";
        drive(10'b01_0001_0000, 10'b01_0001_0000, 1, 0);
        cmp("vec_o lowest index", int'(vec_o), 8'h23);
        drive(10'b01_0000_0000, 10'b01_0001_0000, 0, 1);

        // R6 last slot vector
        tag = "R6";
        drive(10'b10_0000_0000, 10'h000, 1, 0);
        cmp("vec_o slot9", int'(vec_o), 8'h4B);
        drive(10'h000, 10'h000, 0, 0);
        cmp("vec_o idle", int'(vec_o), 0);

        // R3 equal tier (low) held off while low in service
        tag = "R3";
        drive(10'b00_0000_1000, 10'h000, 1, 0);
        cmp("ack_o equal tier", int'(ack_o), 0);
        cmp("cur_tier_o held", int'(cur_tier_o), 1);

        // R8 build a three-deep nest: high, then top
        tag = "R8";
        drive(10'b00_0010_0000, 10'b00_0010_0001, 1, 0);
        cmp("cur_tier_o high", int'(cur_tier_o), 2);
        drive(10'b00_0000_0001, 10'b00_0010_0001, 1, 0);
        cmp("cur_tier_o top", int'(cur_tier_o), 3);

        // R9 reti and accept together: pop only
        tag = "R9";
        drive(10'b00_0000_0010, 10'b00_0000_0011, 1, 1);
        cmp("ack_o with reti", int'(ack_o), 0);
        cmp("cur_tier_o after pop", int'(cur_tier_o), 2);

        tag = "R8";
        drive(10'h000, 10'h000, 0, 1);
        cmp("cur_tier_o restored low", int'(cur_tier_o), 1);
        drive(10'h000, 10'h000, 0, 1);
        drive(10'h000, 10'h000, 0, 1);
        cmp("cur_tier_o empty pop", int'(cur_tier_o), 0);

        // R11 irq follows eligibility combinationally
        tag = "R11";
        drive(10'b00_0000_0100, 10'h000, 0, 0);
        cmp("irq_o pending", int'(irq_o), 1);

        // R2 mixed tier selects, random traffic with sticky requests
        tag = "R2";
        begin
            logic [9:0] pend = '0;
            logic [9:0] sel = 10'b10_1010_0101;
            for (int n = 0; n < 6000; n++) begin
                logic [9:0] nreq;
                int w;
                w = (e_ack) ? (e_vec - 3) / 8 : -1;
                if (w >= 0) pend[w] = 1'b0;
                nreq = 10'($urandom) & 10'($urandom) & 10'($urandom);
                pend = pend | nreq;
                if ((n % 500) == 0) sel = 10'($urandom);
                drive(pend, sel, ($urandom % 3) != 0, ($urandom % 4) == 0);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule